// File: doc/BRIEF.md
# Pulse-Width Tape Byte Decoder

The block turns a serial tape signal into bytes in memory. The tape carries one bit per pulse period, and a period runs from one falling edge to the next. An external synchroniser turns each falling edge into a single-cycle pulse. At every such pulse the block reloads a one-shot down-counter with a programmable threshold. When the next pulse arrives, the bit is 1 if the counter has already run out and 0 if it has not.

Bits are gathered least significant first into bytes. Each complete byte is written to a memory port at an address that starts from a programmed value and counts up. The stream has no lead-in, no sync pattern and no checksum, so it is framed only by the byte count. Decoding ends when the address reaches a programmed end address, which is exclusive.

A controller programs the threshold, the start address and the end address, then pulses the start command. It then waits for the done flag. With a clock of about 1 MHz, a threshold of 0x01B0 separates the faster recording's short and long periods, and 0x0280 does the same for the slower recording.

Top module: `tape_byte_decoder`

## Requirements
- R1: A start pulse while idle sets busy and clears done in the next cycle, and it latches the start and end addresses.
- R2: A start pulse with start address equal to end address writes nothing. In the next cycle done is 1 and busy stays 0.
- R3: After a start, the first edge pulse only reloads the timer and produces no bit. Each later edge ends one bit period.
- R4: Let P be the number of clock cycles from one edge pulse to the next, and T the threshold. The bit is 1 when P > T and 0 when P <= T. An edge that lands in the cycle where the counter reaches zero therefore yields 1.
- R5: Bits are packed least significant first. The first decoded bit of a byte lands in data bit 0 and the eighth in data bit 7.
- R6: After each eighth bit, the write strobe is high for exactly one cycle, in the cycle after that bit's edge. It carries the byte and the current address. The first address is the start address, and each write adds 1.
- R7: The end address is exclusive. The write to address end-1 ends the load. In that same cycle busy falls and done rises, and done stays high until the next accepted start.
- R8: A start pulse while busy has no effect on the load in progress, on its addresses or on its data.
- R9: Once the counter reaches zero it stays at zero, with the expired state held until the next edge. A period much longer than T still decodes as 1.
- R10: After reset, busy, done and the write strobe are 0, and the bit packer is empty.
- R11: With T = 0x01B0 and one cycle per microsecond, short periods of 360–400 and long periods of 528–595 decode correctly. With T = 0x0280, short periods near 500 and long periods near 750 decode correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| edge_pulse | input | 1 | Single-cycle pulse per synchronised falling tape edge |
| threshold | input | TW (16) | Down-counter reload value in clock cycles |
| start_addr | input | AW (16) | First write address |
| end_addr | input | AW (16) | Exclusive end address |
| start | input | 1 | Start command pulse |
| wr_addr | output | AW (16) | Write address |
| wr_data | output | BITS (8) | Byte to write |
| wr_en | output | 1 | Write strobe, one cycle per byte |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load completed |

## Verification
The assertions assume the following about the inputs:
- edge_pulse is never high in two adjacent cycles, since an external synchroniser delivers it.
- Edge pulses are at least two cycles apart, which keeps two writes from being adjacent.
- threshold is held steady while a load runs.

The stimulus meets these assumptions. It drives each edge as a one-cycle pulse followed by a gap of at least 20 cycles, and it changes the threshold only between loads. Start pulses sent during a load fall inside those gaps and never coincide with an edge, which is the case the ignore check covers.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/tbd_pulse_timer.sv
module tbd_pulse_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic [TW-1:0] threshold,
    output logic [TW-1:0] count,
    output logic          expired
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (reload) begin
            tmr_d.cnt = threshold;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign count   = tmr_q.cnt;
    assign expired = (tmr_q.cnt == '0);
endmodule

// File: rtl/tbd_bit_packer.sv
module tbd_bit_packer #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic            byte_full,
    output logic [BITS-1:0] byte_next
);
    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    typedef struct packed {
        logic [BITS-1:0] sr;
        logic [CW-1:0]   cnt;
    } pk_t;

    pk_t pk_d, pk_q;

    assign byte_next = {bit_in, pk_q.sr[BITS-1:1]};
    assign byte_full = shift_en && (pk_q.cnt == LAST);

    always_comb begin
        pk_d = pk_q;
        if (clr) begin
            pk_d = '0;
        end else if (shift_en) begin
            pk_d.sr  = byte_next;
            pk_d.cnt = (pk_q.cnt == LAST) ? '0 : pk_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end
endmodule

// File: rtl/tbd_load_seq.sv
module tbd_load_seq
    import tbd_pkg::*;
#(
    parameter int AW   = 16,
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            edge_pulse,
    input  logic [AW-1:0]   start_addr,
    input  logic [AW-1:0]   end_addr,
    input  logic            byte_full,
    input  logic [BITS-1:0] byte_next,
    output logic            reload,
    output logic            shift_en,
    output logic            clr,
    output logic [AW-1:0]   wr_addr,
    output logic [BITS-1:0] wr_data,
    output logic            wr_en,
    output logic            busy,
    output logic            done
);
    typedef struct packed {
        seq_state_e      st;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   last;
        logic [AW-1:0]   wa;
        logic [BITS-1:0] wd;
        logic            we;
        logic            dn;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [AW-1:0] addr_inc;

    assign addr_inc = seq_q.addr + 1'b1;
    assign reload   = edge_pulse && (seq_q.st != ST_IDLE);
    assign shift_en = edge_pulse && (seq_q.st == ST_RUN);
    assign clr      = start && (seq_q.st == ST_IDLE);

    always_comb begin
        seq_d    = seq_q;
        seq_d.we = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.addr = start_addr;
                    seq_d.last = end_addr;
                    seq_d.dn   = (start_addr == end_addr);
                    if (start_addr != end_addr) seq_d.st = ST_ARM;
                end
            end
            ST_ARM: begin
                if (edge_pulse) seq_d.st = ST_RUN;
            end
            ST_RUN: begin
                if (byte_full) begin
                    seq_d.we   = 1'b1;
                    seq_d.wa   = seq_q.addr;
                    seq_d.wd   = byte_next;
                    seq_d.addr = addr_inc;
                    if (addr_inc == seq_q.last) begin
                        seq_d.st = ST_IDLE;
                        seq_d.dn = 1'b1;
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign wr_addr = seq_q.wa;
    assign wr_data = seq_q.wd;
    assign wr_en   = seq_q.we;
    assign busy    = (seq_q.st != ST_IDLE);
    assign done    = seq_q.dn;
endmodule

// File: rtl/tape_byte_decoder.sv
module tape_byte_decoder #(
    parameter int TW   = 16,
    parameter int AW   = 16,
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            edge_pulse,
    input  logic [TW-1:0]   threshold,
    input  logic [AW-1:0]   start_addr,
    input  logic [AW-1:0]   end_addr,
    input  logic            start,
    output logic [AW-1:0]   wr_addr,
    output logic [BITS-1:0] wr_data,
    output logic            wr_en,
    output logic            busy,
    output logic            done
);
    logic            tmr_reload;
    logic [TW-1:0]   tmr_count;
    logic            tmr_expired;
    logic            pk_shift;
    logic            pk_clr;
    logic            pk_full;
    logic [BITS-1:0] pk_next;

    tbd_pulse_timer #(.TW(TW)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (tmr_reload),
        .threshold (threshold),
        .count     (tmr_count),
        .expired   (tmr_expired)
    );

    tbd_bit_packer #(.BITS(BITS)) packer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pk_clr),
        .shift_en  (pk_shift),
        .bit_in    (tmr_expired),
        .byte_full (pk_full),
        .byte_next (pk_next)
    );

    tbd_load_seq #(.AW(AW), .BITS(BITS)) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .edge_pulse (edge_pulse),
        .start_addr (start_addr),
        .end_addr   (end_addr),
        .byte_full  (pk_full),
        .byte_next  (pk_next),
        .reload     (tmr_reload),
        .shift_en   (pk_shift),
        .clr        (pk_clr),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_en      (wr_en),
        .busy       (busy),
        .done       (done)
    );
endmodule

// File: rtl/tape_byte_decoder_chk.sv
module tape_byte_decoder_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          edge_pulse,
    input logic          start,
    input logic [TW-1:0] threshold,
    input logic          wr_en,
    input logic          busy,
    input logic          done,
    input logic          tmr_reload,
    input logic [TW-1:0] tmr_count,
    input logic          tmr_expired
);
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done); // R7

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !edge_pulse |=> busy && !done); // R8

    AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_expired && !tmr_reload |=> tmr_expired); // R9

    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_reload |=> tmr_count == $past(threshold)); // R4

    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en); // R6

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !wr_en); // R3
endmodule

bind tape_byte_decoder tape_byte_decoder_chk #(.TW(TW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_pulse  (edge_pulse),
    .start       (start),
    .threshold   (threshold),
    .wr_en       (wr_en),
    .busy        (busy),
    .done        (done),
    .tmr_reload  (tmr_reload),
    .tmr_count   (tmr_count),
    .tmr_expired (tmr_expired)
);

// File: tb/tape_byte_decoder_tb_top.sv
`timescale 1ns/1ps
module tape_byte_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        edge_pulse = 1'b0;
    logic [15:0] threshold = 16'h01B0;
    logic [15:0] start_addr = '0;
    logic [15:0] end_addr = '0;
    logic        start = 1'b0;
    logic [15:0] wr_addr;
    logic [7:0]  wr_data;
    logic        wr_en;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [15:0] exp_addr_q[$];
    logic [7:0]  exp_data_q[$];

    always #2 clk = ~clk;

    tape_byte_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .edge_pulse(edge_pulse), .threshold(threshold),
        .start_addr(start_addr), .end_addr(end_addr), .start(start),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_en(wr_en), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on every write strobe (R5, R6)
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R6 unexpected write", int'(wr_addr), 0);
            end else begin
                logic [15:0] ea;
                logic [7:0]  ed;
                ea = exp_addr_q.pop_front();
                ed = exp_data_q.pop_front();
                check(wr_addr == ea, "R6 write address", int'(wr_addr), int'(ea));
                check(wr_data == ed, "R5 R4 R11 write data", int'(wr_data), int'(ed));
            end
        end
    end

    task automatic fire_edge();
        edge_pulse = 1'b1;
        @(negedge clk);
        edge_pulse = 1'b0;
    endtask

    // wait until the next edge is P cycles after the previous one; optional stray start
    task automatic gap(input int p, input bit poke);
        if (poke) begin
            start = 1'b1;
            start_addr = 16'hBEEF;
            end_addr = 16'hBEEF;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1 && done == 1'b0, "R8 start while busy", int'(busy), 1);
            repeat (p - 2) @(negedge clk);
        end else begin
            repeat (p - 1) @(negedge clk);
        end
    endtask

    function automatic int period_for(input int mode, input bit b, input int idx);
        case (mode)
            0: return b ? 528 + int'($urandom % 68) : 360 + int'($urandom % 41);
            1: return b ? 730 + int'($urandom % 40) : 480 + int'($urandom % 40);
            default: return b ? ((idx % 2 == 0) ? 21 : 200) : 20; // R4 R9 edges: T, T+1, far beyond
        endcase
    endfunction

    // driver: pushes expected bytes then plays the pulse train
    task automatic run_load(input logic [15:0] sa, input int n, input logic [15:0] thr,
                            input int mode, input bit poke_mid);
        logic [7:0] bytes[$];
        threshold = thr;
        start_addr = sa;
        end_addr = sa + 16'(n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = (i == 0) ? 8'h01 : 8'($urandom);
            bytes.push_back(v);
            exp_addr_q.push_back(sa + 16'(i));
            exp_data_q.push_back(v);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1 && done == 1'b0, "R1 start accepted", int'({busy, done}), 2);
        fire_edge(); // arming edge, no bit (R3)
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                bit last;
                last = (i == n - 1) && (b == 7);
                gap(period_for(mode, bytes[i][b], i * 8 + b), poke_mid && i == 0 && b == 3);
                if (last) check(done == 1'b0 && busy == 1'b1, "R7 not done early", int'(done), 0);
                fire_edge();
            end
        end
        check(done == 1'b1 && busy == 1'b0, "R7 done with last write", int'({busy, done}), 1);
        check(wr_en == 1'b1, "R6 final strobe aligned", int'(wr_en), 1);
        @(negedge clk);
        check(exp_addr_q.size() == 0, "R7 all bytes written", exp_addr_q.size(), 0);
        check(done == 1'b1, "R7 done held", int'(done), 1);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0, "R10 reset state",
              int'({busy, done, wr_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R10 after reset release", int'({busy, done}), 0);

        // R2: empty load
        start_addr = 16'h0040;
        end_addr = 16'h0040;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1 && busy == 1'b0, "R2 empty load done", int'({busy, done}), 1);
        repeat (4) @(negedge clk);
        check(wr_en == 1'b0 && busy == 1'b0, "R2 no activity", int'({busy, wr_en}), 0);

        // R11 R5 R3 R8: default threshold, jittered periods, stray start mid-load
        run_load(16'h0800, 8, 16'h01B0, 0, 1'b1);
        // R4 R9: exact boundary periods with a small threshold
        run_load(16'h1FFE, 3, 16'd20, 2, 1'b0);
        // R11: slower variant threshold
        run_load(16'h0100, 2, 16'h0280, 1, 1'b0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule